// File: doc/BRIEF.md
# Memory-Mapped Byte Serial Register Front-End

This block is a bus-slave register window that sits between a processor bus and a byte-wide serial port. Software sends a character by writing a word to the transmit register. The block forwards the low byte to a valid/ready transmit stream. Incoming characters arrive on a valid/ready receive stream. Each one lands in a single-entry holding register, and software reads it back over the bus.

A status register tells software two things: whether a received byte is waiting, and whether the transmit side can take another byte. Reading the receive data register consumes the waiting byte. Until that read, the receive stream is back-pressured, so a byte that is not read is never overwritten. Bit-level shifting, baud timing, FIFOs and interrupts belong to other blocks.

The window is 0x18 bytes long and accepts only aligned 32-bit word accesses. The register map is:

- transmit data at byte offset 0x00 (write-only; it reads as zero);
- receive data at byte offset 0x04;
- status at byte offset 0x14.

Top module: `bytereg_uart`

## Requirements
- R1: After reset, the status register reads 0x0000_0002, the receive data register reads 0, `tx_valid` is low and `rx_ready` is high.
- R2: The status register layout is fixed. Bit 0 is "receive byte waiting" and bit 1 is "transmit side idle". Bits 31 to 2 always read as 0.
- R3: A receive byte is taken only on a cycle where `rx_valid` and `rx_ready` are both high. Taking it stores `rx_data` in the holding register and sets status bit 0. `rx_ready` is always the inverse of status bit 0, so a byte offered while a byte is waiting is not taken.
- R4: A bus read of offset 0x04 returns the held byte in bits 7:0, with bits 31:8 zero. The same access clears status bit 0, so `rx_ready` is high on the following cycle.
- R5: A byte can be taken in the same cycle as a read of offset 0x04. In that case the read returns the previously held byte, the new byte is stored, and status bit 0 ends set.
- R6: A bus write to offset 0x00 while status bit 1 is set raises `tx_valid` on the next cycle, with `tx_data` equal to write data bits 7:0. If `tx_ready` is high, `tx_valid` lasts exactly one cycle.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds steady and status bit 1 reads 0. A write to offset 0x00 made during that time is dropped. Status bit 1 returns to 1 on the cycle after the handshake.
- R8: Bus writes to the status register at offset 0x14 change nothing.
- R9: Reads of any other offset return 0, and writes to them change nothing. Those offsets are 0x08, 0x0C, 0x10, any offset of 0x18 or above, and any address whose low two bits are not zero. A read of offset 0x00 also returns 0.
- R10: Read data appears on `bus_rdata` on the cycle after the bus access. It reflects register state as it was before that access's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | BYTE_W | Transmit byte |
| tx_ready | input | 1 | Transmit sink ready |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | BYTE_W | Receive byte |
| rx_ready | output | 1 | High while the holding register is empty |

## Verification
Each result has a fixed due time:

- `bus_rdata` is due one edge after the read.
- `tx_valid` and `tx_data` are due one edge after the write.
- The `rx_ready` drop is due one edge after a byte is taken.
- The `rx_ready` rise is due one edge after the receive read.

The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It then samples at the next falling edge, so each check sees the cycle its requirement names. The stall cases count further edges explicitly while `tx_ready` is held low.

The sweeps cover:

- all 256 receive bytes;
- all 256 transmit bytes;
- every byte address 0 to 31 for both reads and writes.

// File: rtl/bytereg_uart_pkg.sv
// Package: shared register-target type and status bit positions for the
// byte serial register front-end.
package bytereg_uart_pkg;

    // Which register a bus access resolves to.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TX   = 2'd1,
        TGT_RX   = 2'd2,
        TGT_STAT = 2'd3
    } reg_target_e;

    // Status bit positions (software decodes these).
    localparam int STAT_RX_WAIT_BIT = 0;
    localparam int STAT_TX_IDLE_BIT = 1;

endpackage

// File: rtl/bytereg_uart_decode.sv
// Module: bytereg_uart_decode
// Resolves a bus access to one register target.
// Assumes: an access is one cycle wide.
// Aligned, in-window, mapped offsets hit a register. Everything else
// (misaligned, out of window, unmapped) resolves to TGT_NONE.
module bytereg_uart_decode
    import bytereg_uart_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int WINDOW_BYTES = 24,
    parameter int TX_OFS       = 0,
    parameter int RX_OFS       = 4,
    parameter int STAT_OFS     = 20
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_target_e       target,
    output logic              acc_rd,
    output logic              acc_wr
);
    localparam logic [ADDR_W-1:0] WIN_END  = ADDR_W'(WINDOW_BYTES);
    localparam logic [ADDR_W-1:0] TX_ADDR  = ADDR_W'(TX_OFS);
    localparam logic [ADDR_W-1:0] RX_ADDR  = ADDR_W'(RX_OFS);
    localparam logic [ADDR_W-1:0] ST_ADDR  = ADDR_W'(STAT_OFS);

    logic aligned;
    logic in_window;

    // Purpose: qualify the address as a legal word access inside the window.
    always_comb begin
        aligned   = (bus_addr[1:0] == 2'b00);
        in_window = (bus_addr < WIN_END);
    end

    // Purpose: map a legal address to its register target.
    always_comb begin
        target = TGT_NONE;
        if (aligned && in_window) begin
            if (bus_addr == TX_ADDR)      target = TGT_TX;
            else if (bus_addr == RX_ADDR) target = TGT_RX;
            else if (bus_addr == ST_ADDR) target = TGT_STAT;
        end
    end

    // Purpose: split the strobe into read and write qualifiers.
    always_comb begin
        acc_rd = bus_sel && !bus_we;
        acc_wr = bus_sel && bus_we;
    end

endmodule

// File: rtl/bytereg_uart_tx.sv
// Module: bytereg_uart_tx
// One-entry transmit holding stage.
// A load while idle captures a byte and raises tx_valid on the next cycle.
// The byte stays on tx_data until tx_ready completes the handshake.
// Assumes: a load while busy is dropped by this stage (not queued).
module bytereg_uart_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              idle
);
    logic              pending_q;
    logic [BYTE_W-1:0] byte_q;

    // Purpose: hold a byte from load until the sink accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            byte_q    <= '0;
        end else if (pending_q) begin
            if (tx_ready) pending_q <= 1'b0;
        end else if (load) begin
            pending_q <= 1'b1;
            byte_q    <= load_byte;
        end
    end

    // Purpose: expose the holding stage on the stream and to the status bit.
    always_comb begin
        tx_valid = pending_q;
        tx_data  = byte_q;
        idle     = !pending_q;
    end

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R6
    tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_valid);

endmodule

// File: rtl/bytereg_uart_rx.sv
// Module: bytereg_uart_rx
// One-entry receive holding register.
// A byte is taken only while empty. A bus read clears the waiting flag.
// An arrival in the same cycle as a clear leaves the flag set.
// Assumes: rx_data is stable whenever rx_valid is high.
module bytereg_uart_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              clear,
    output logic              waiting,
    output logic [BYTE_W-1:0] held
);
    logic              full_q;
    logic [BYTE_W-1:0] held_q;
    logic              take;

    // Purpose: a byte is taken on a completed stream handshake.
    always_comb begin
        rx_ready = !full_q;
        take     = rx_valid && !full_q;
    end

    // Purpose: store taken byte; arrival wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            held_q <= '0;
        end else if (take) begin
            full_q <= 1'b1;
            held_q <= rx_data;
        end else if (clear) begin
            full_q <= 1'b0;
        end
    end

    // Purpose: drive status and read path.
    always_comb begin
        waiting = full_q;
        held    = held_q;
    end

    // R3
    rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> (waiting && held == $past(rx_data)));

    // R4
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !(rx_valid && rx_ready)) |=> rx_ready);

    // R3
    rx_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !clear) |=> (!rx_ready && $stable(held)));

endmodule

// File: rtl/bytereg_uart.sv
// Module: bytereg_uart (top)
// Bus-slave register front-end for a byte serial port.
// Registers: transmit data, receive data and status, in a word-access window.
// Read data is registered: it is valid the cycle after a read access.
// Assumes: at most one bus access per cycle; no wait states.
module bytereg_uart
    import bytereg_uart_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 32,
    parameter int BYTE_W       = 8,
    parameter int WINDOW_BYTES = 24,
    parameter int TX_OFS       = 0,
    parameter int RX_OFS       = 4,
    parameter int STAT_OFS     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready
);
    localparam int STAT_BITS = 2;

    reg_target_e       target;
    logic              acc_rd;
    logic              acc_wr;
    logic              wr_tx;
    logic              rd_rx;
    logic              tx_idle;
    logic              rx_waiting;
    logic [BYTE_W-1:0] rx_held;
    logic [DATA_W-1:0] status_word;
    logic              unused_wdata_hi;
    logic [DATA_W-1:0] rdata_q;

    bytereg_uart_decode #(
        .ADDR_W      (ADDR_W),
        .WINDOW_BYTES(WINDOW_BYTES),
        .TX_OFS      (TX_OFS),
        .RX_OFS      (RX_OFS),
        .STAT_OFS    (STAT_OFS)
    ) i_decode (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .target  (target),
        .acc_rd  (acc_rd),
        .acc_wr  (acc_wr)
    );

    // Purpose: derive register side effects from the decoded access.
    always_comb begin
        wr_tx           = acc_wr && (target == TGT_TX);
        rd_rx           = acc_rd && (target == TGT_RX);
        unused_wdata_hi = ^bus_wdata[DATA_W-1:BYTE_W];
    end

    bytereg_uart_tx #(
        .BYTE_W(BYTE_W)
    ) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_tx),
        .load_byte(bus_wdata[BYTE_W-1:0]),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .idle     (tx_idle)
    );

    bytereg_uart_rx #(
        .BYTE_W(BYTE_W)
    ) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_ready(rx_ready),
        .clear   (rd_rx),
        .waiting (rx_waiting),
        .held    (rx_held)
    );

    // Purpose: assemble the status word; upper bits are constant zero.
    always_comb begin
        status_word                   = '0;
        status_word[STAT_RX_WAIT_BIT] = rx_waiting;
        status_word[STAT_TX_IDLE_BIT] = tx_idle;
    end

    // Purpose: register the read data of the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (acc_rd) begin
            case (target)
                TGT_RX:   rdata_q <= DATA_W'(rx_held);
                TGT_STAT: rdata_q <= status_word;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && (target == TGT_NONE || target == TGT_TX)) |=> (bus_rdata == '0));

    // R2
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && target == TGT_STAT) |=> (bus_rdata[DATA_W-1:STAT_BITS] == '0));

    // R7
    tx_busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && target == TGT_STAT && tx_valid) |=> !bus_rdata[STAT_TX_IDLE_BIT]);

    // R8
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && target != TGT_TX && !tx_valid) |=> !tx_valid);

endmodule

// File: tb/test_bytereg_uart.sv
// Bench for bytereg_uart: sweeps receive bytes, transmit bytes and every
// byte address. Inputs change on falling edges; outputs are sampled on
// the falling edge after the rising edge that produces them.
module test_bytereg_uart;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tx_valid;
    logic [BYTE_W-1:0] tx_data;
    logic              tx_ready = 1'b1;
    logic              rx_valid = 1'b0;
    logic [BYTE_W-1:0] rx_data = '0;
    logic              rx_ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bytereg_uart i_bytereg_uart (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Read: access across one rising edge, data sampled at the next falling edge.
    task automatic bus_read(input int addr, output logic [31:0] data);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr);
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        data = bus_rdata;
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);
        bus_read(20, rd); chk("R1 status", rd, 32'h2);
        bus_read(4, rd);  chk("R1 rx data", rd, 0);

        // R3 R4 R2: sweep every receive byte
        for (int v = 0; v < 256; v++) begin
            chk("R3 ready before", 32'(rx_ready), 1);
            rx_push(8'(v));
            chk("R3 ready after take", 32'(rx_ready), 0);
            if (v % 16 == 3) begin
                rx_push(8'(~v)); // not taken: holding register full
                chk("R3 no overwrite ready", 32'(rx_ready), 0);
            end
            bus_read(20, rd); chk("R2 status waiting", rd, 32'h3);
            bus_read(4, rd);  chk("R4 rx byte", rd, 32'(v));
            chk("R4 ready after read", 32'(rx_ready), 1);
            bus_read(20, rd); chk("R4 status cleared", rd, 32'h2);
        end

        // R5: arrival during a read of the empty receive register
        rx_valid = 1'b1; rx_data = 8'h5A;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'd4;
        @(posedge clk); @(negedge clk);
        rx_valid = 1'b0; bus_sel = 1'b0;
        chk("R5 read returns old byte", bus_rdata, 32'hFF);
        chk("R5 ready low", 32'(rx_ready), 0);
        bus_read(20, rd); chk("R5 flag set", rd, 32'h3);
        bus_read(4, rd);  chk("R5 new byte", rd, 32'h5A);

        // R6: sweep every transmit byte with a ready sink
        tx_ready = 1'b1;
        for (int v = 0; v < 256; v++) begin
            bus_write(0, {8'(v ^ 8'h3C), 8'hC3, 8'h81, 8'(v)});
            chk("R6 tx_valid", 32'(tx_valid), 1);
            chk("R6 tx_data", 32'(tx_data), 32'(v));
            @(negedge clk);
            chk("R6 single pulse", 32'(tx_valid), 0);
        end

        // R7: stalled sink
        tx_ready = 1'b0;
        bus_write(0, 32'h0000_00A7);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 valid held", 32'(tx_valid), 1);
            chk("R7 data held", 32'(tx_data), 32'hA7);
        end
        bus_read(20, rd); chk("R7 status busy", rd, 32'h0);
        bus_write(0, 32'h0000_0042);
        chk("R7 data after dropped write", 32'(tx_data), 32'hA7);
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R7 valid drops", 32'(tx_valid), 0);
        bus_read(20, rd); chk("R7 status idle", rd, 32'h2);
        @(negedge clk);
        chk("R7 dropped byte not sent", 32'(tx_valid), 0);

        // R9 R10 R2: read sweep over every byte address with a byte waiting
        rx_push(8'hA5);
        for (int a = 0; a < 32; a++) begin
            if (a != 4) begin
                bus_read(a, rd);
                chk(a == 20 ? "R2 status read" : "R9 unmapped read", rd, (a == 20) ? 32'h3 : 32'h0);
            end
        end

        // R8 R9: write sweep everywhere except transmit; nothing changes
        for (int a = 1; a < 32; a++) begin
            bus_write(a, 32'hFFFF_FFFF);
            chk("R8 no tx from write", 32'(tx_valid), 0);
        end
        bus_read(20, rd); chk("R8 status unchanged", rd, 32'h3);
        chk("R9 rx_ready unchanged", 32'(rx_ready), 0);
        bus_read(4, rd); chk("R10 rx byte intact", rd, 32'hA5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule